// File: doc/BRIEF.md
# Virtual-Link Segment Demultiplexer

This block sits at the receive end of one fast aggregated link. The link carries segments from several virtual links, interleaved one segment after another. Each segment opens with a one- or two-byte header. The block removes that header and sends the payload bytes to the output port that the segment's link identifier selects. On every output it rebuilds the original frame, marking the first byte and the last byte of each frame.

Forwarding is cut-through. A frame's first byte leaves on its port a fixed three cycles after it enters, even while later segments of the same frame are still to come. The header bits alone decide where a frame starts and ends, so the block never holds a whole frame. Payload bytes, including any trailing checksum, pass through unmodified. A lost segment therefore shows up downstream as a checksum failure.

Malformed traffic is handled in four ways. A frame that is re-opened before it ends is closed with an error marker. A stray continuation segment is dropped and counted. A segment with an empty length field or no payload raises a protocol pulse. When an open frame on an output runs dry, an underrun flag shows the gap.

Top module: `vlink_demux`

## Requirements
- R1: Header byte 0 bits 3:0 give the link ID. Every forwarded payload byte of the segment appears, unmodified and in order, on output port ID and on no other port.
- R2: A segment with header byte 0 bit 7 set opens a frame on its link. The first payload byte forwarded after the open carries out_sof. Later segments with bit 7 clear append to that frame without out_sof.
- R3: A segment with header byte 0 bit 6 set closes its link's frame. Its last forwarded payload byte carries out_eof.
- R4: When header byte 0 bit 5 is set, byte 1 is header, and its bits 5:0 give a count N. Only the first N payload bytes are forwarded and the rest of the segment is dropped. If fewer than N bytes are present, all of them are forwarded.
- R5: A count of 0, or a segment that ends before any payload byte, pulses proto_err for one cycle. No byte of that segment is forwarded. A header-only segment changes no link state.
- R6: A payload byte sampled at a clock edge appears on its output port three clock edges later, whether or not its segment or frame has ended.
- R7: A start segment on a link whose frame is open first emits one entry on that port with out_err=1, out_eof=1, out_sof=0 and data 0x00. The new frame then follows.
- R8: A continuation segment (bit 7 clear) on a link with no open frame is discarded, and orphan_cnt increases by exactly one.
- R9: out_underrun is high in a cycle exactly when that port has delivered out_sof but not yet out_eof, and presents no byte in that cycle.
- R10: While rst is high, every out_valid, out_underrun and proto_err is 0 and orphan_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is header byte 0 of a segment |
| in_last | input | 1 | Byte is the final byte of a segment |
| out_valid | output | 16 | Per-port byte valid |
| out_data | output | 128 | Per-port byte, port p in bits 8p+7:8p |
| out_sof | output | 16 | Per-port first byte of frame |
| out_eof | output | 16 | Per-port last byte of frame |
| out_err | output | 16 | Per-port abort marker |
| out_underrun | output | 16 | Per-port gap inside an open frame |
| proto_err | output | 1 | One-cycle pulse for a malformed segment |
| orphan_cnt | output | 8 | Count of dropped continuation segments |

## Verification
The case hardest to reach is an open frame interrupted by a new start segment on the same link while other links keep interleaving. It must produce exactly one abort entry ahead of the new frame's first byte, and no entry on any other port. The stimulus leaves frames open on several links at once, then re-opens one of them. A scoreboard tracks the frame state of each link and predicts the full entry sequence of every port. Underrun is provoked by stalling the input mid-frame, and cut-through latency is probed while the segment is still entering.

// File: rtl/vlink_pkg.sv
package vlink_pkg;
  localparam int HB_START = 7;
  localparam int HB_END   = 6;
  localparam int HB_LEN   = 5;

  typedef struct packed {
    logic       err;
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } qent_t;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_LEN  = 2'd1,
    P_PAY  = 2'd2
  } pstate_t;

  localparam qent_t ABORT_ENT = '{err: 1'b1, sof: 1'b0, eof: 1'b1, data: 8'h00};
endpackage

// File: rtl/vlink_parse.sv
module vlink_parse
  import vlink_pkg::*;
#(
  parameter int LINK_W = 4,
  parameter int CNT_W  = 8,
  localparam int NPORT = 1 << LINK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic [NPORT-1:0] wr_en,
  output qent_t            wr_ent,
  output logic             proto_err,
  output logic [CNT_W-1:0] orphan_cnt
);
  pstate_t           st;
  logic [LINK_W-1:0] cur_id;
  logic              cur_en;
  logic              cur_ln;
  logic [5:0]        rem;
  logic [NPORT-1:0]  open_q;
  logic [NPORT-1:0]  sofp_q;

  logic [LINK_W-1:0] hid;
  logic              hst, hen, hln;
  logic              fwd, last_fwd;

  always_comb begin
    hid      = in_data[LINK_W-1:0];
    hst      = in_data[HB_START];
    hen      = in_data[HB_END];
    hln      = in_data[HB_LEN];
    fwd      = (st == P_PAY) && (!cur_ln || rem != 6'd0);
    last_fwd = cur_en && (in_last || (cur_ln && rem == 6'd1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= P_IDLE;
      cur_id     <= '0;
      cur_en     <= 1'b0;
      cur_ln     <= 1'b0;
      rem        <= '0;
      open_q     <= '0;
      sofp_q     <= '0;
      wr_en      <= '0;
      wr_ent     <= '0;
      proto_err  <= 1'b0;
      orphan_cnt <= '0;
    end else begin
      wr_en     <= '0;
      proto_err <= 1'b0;
      if (in_valid) begin
        if (in_first) begin
          cur_id <= hid;
          cur_en <= hen;
          cur_ln <= hln;
          if (in_last) begin
            proto_err <= 1'b1;
            st        <= P_IDLE;
          end else if (hst) begin
            if (open_q[hid]) begin
              wr_en[hid] <= 1'b1;
              wr_ent     <= ABORT_ENT;
            end
            open_q[hid] <= 1'b1;
            sofp_q[hid] <= 1'b1;
            st          <= hln ? P_LEN : P_PAY;
          end else if (!open_q[hid]) begin
            orphan_cnt <= orphan_cnt + 1'b1;
            st         <= P_IDLE;
          end else begin
            st <= hln ? P_LEN : P_PAY;
          end
        end else begin
          case (st)
            P_LEN: begin
              if (in_data[5:0] == 6'd0 || in_last) begin
                proto_err <= 1'b1;
                st        <= P_IDLE;
              end else begin
                rem <= in_data[5:0];
                st  <= P_PAY;
              end
            end
            P_PAY: begin
              if (fwd) begin
                wr_en[cur_id]  <= 1'b1;
                wr_ent.err     <= 1'b0;
                wr_ent.sof     <= sofp_q[cur_id];
                wr_ent.eof     <= last_fwd;
                wr_ent.data    <= in_data;
                sofp_q[cur_id] <= 1'b0;
                if (last_fwd) open_q[cur_id] <= 1'b0;
                if (cur_ln) rem <= rem - 6'd1;
              end
              if (in_last) st <= P_IDLE;
            end
            default: st <= P_IDLE;
          endcase
        end
      end
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en)); // R1
  AST_PROTO_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (wr_en == '0)); // R5
  AST_ORPHAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (orphan_cnt != $past(orphan_cnt)) |-> (orphan_cnt - $past(orphan_cnt) == CNT_W'(1))); // R8
endmodule

// File: rtl/vlink_queue.sv
module vlink_queue
  import vlink_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  qent_t wr_ent,
  output logic  q_vld,
  output qent_t q_ent
);
  qent_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          pop;

  assign pop = (cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_ent;
    if (pop) q_ent <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      q_vld  <= 1'b0;
    end else begin
      q_vld <= pop;
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, wr_en} - {{AW{1'b0}}, pop};
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cnt != (AW+1)'(DEPTH))); // R1
endmodule

// File: rtl/vlink_port.sv
module vlink_port
  import vlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       q_vld,
  input  qent_t      q_ent,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_err,
  output logic       out_underrun
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      out_err      <= 1'b0;
      out_underrun <= 1'b0;
      open_q       <= 1'b0;
    end else begin
      out_valid    <= q_vld;
      out_data     <= q_vld ? q_ent.data : 8'h00;
      out_sof      <= q_vld && q_ent.sof;
      out_eof      <= q_vld && q_ent.eof;
      out_err      <= q_vld && q_ent.err;
      out_underrun <= !q_vld && open_q;
      if (q_vld) begin
        if (q_ent.eof) open_q <= 1'b0;
        else if (q_ent.sof) open_q <= 1'b1;
      end
    end
  end

  AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_underrun |-> !out_valid); // R9
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_eof && !out_sof)); // R7
  AST_EOF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eof) |=> !out_underrun); // R3
endmodule

// File: rtl/vlink_demux.sv
module vlink_demux
  import vlink_pkg::*;
#(
  parameter int LINK_W = 4,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  localparam int NPORT = 1 << LINK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_first,
  input  logic               in_last,
  output logic [NPORT-1:0]   out_valid,
  output logic [NPORT*8-1:0] out_data,
  output logic [NPORT-1:0]   out_sof,
  output logic [NPORT-1:0]   out_eof,
  output logic [NPORT-1:0]   out_err,
  output logic [NPORT-1:0]   out_underrun,
  output logic               proto_err,
  output logic [CNT_W-1:0]   orphan_cnt
);
  logic [NPORT-1:0] wr_en;
  qent_t            wr_ent;

  vlink_parse #(.LINK_W(LINK_W), .CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .wr_en(wr_en), .wr_ent(wr_ent),
    .proto_err(proto_err), .orphan_cnt(orphan_cnt)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic  q_vld;
    qent_t q_ent;

    vlink_queue #(.DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst(rst), .wr_en(wr_en[p]), .wr_ent(wr_ent),
      .q_vld(q_vld), .q_ent(q_ent)
    );

    vlink_port u_port (
      .clk(clk), .rst(rst), .q_vld(q_vld), .q_ent(q_ent),
      .out_valid(out_valid[p]), .out_data(out_data[p*8 +: 8]),
      .out_sof(out_sof[p]), .out_eof(out_eof[p]), .out_err(out_err[p]),
      .out_underrun(out_underrun[p])
    );
  end
endmodule

// File: tb/sim_vlink_demux.sv
module sim_vlink_demux;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic [NP-1:0] out_valid, out_sof, out_eof, out_err, out_underrun;
  logic [NP*8-1:0] out_data;
  logic          proto_err;
  logic [7:0]    orphan_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlink_demux u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_err(out_err), .out_underrun(out_underrun), .proto_err(proto_err),
    .orphan_cnt(orphan_cnt)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [10:0] exp_q [NP][$];
  bit    m_open [NP];
  bit    m_sofp [NP];
  int    exp_proto = 0;
  int    seen_proto = 0;
  int    exp_orphan = 0;
  int    und_cnt [NP];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected entries per port and compares.
  always @(negedge clk) begin
    if (!rst) begin
      if (proto_err) seen_proto++;
      for (int p = 0; p < NP; p++) begin
        if (out_underrun[p]) und_cnt[p]++;
        if (out_valid[p]) begin
          logic [10:0] got;
          got = {out_err[p], out_sof[p], out_eof[p], out_data[p*8 +: 8]};
          if (exp_q[p].size() == 0) begin
            check(0, cur_req, $sformatf("unexpected entry port %0d", p), got, 0);
          end else begin
            logic [10:0] e;
            e = exp_q[p].pop_front();
            check(got == e, cur_req, $sformatf("entry port %0d", p), got, e);
          end
        end
      end
    end
  end

  task automatic drive_byte(input logic [7:0] d, input bit f, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Driver: predicts the expected entries from the requirements, then drives.
  task automatic send_seg(input int id, input bit st, input bit en, input bit ln,
                          input int cnt, input int n, input logic [7:0] base,
                          input bit probe);
    bit skip = 0;
    int k;
    if (n == 0 && !ln) begin
      exp_proto++;
      drive_byte({st, en, ln, 1'b0, 4'(id)}, 1'b1, 1'b1);
      return;
    end
    if (st) begin
      if (m_open[id]) exp_q[id].push_back({1'b1, 1'b0, 1'b1, 8'h00});
      m_open[id] = 1; m_sofp[id] = 1;
    end else if (!m_open[id]) begin
      exp_orphan++; skip = 1;
    end
    if (!skip && ln && cnt == 0) begin
      exp_proto++; skip = 1;
    end
    if (!skip) begin
      k = (ln && cnt < n) ? cnt : n;
      for (int i = 0; i < k; i++) begin
        bit eo;
        eo = en && (i == k - 1);
        exp_q[id].push_back({1'b0, m_sofp[id], eo, 8'(base + i)});
        m_sofp[id] = 0;
        if (eo) m_open[id] = 0;
      end
    end
    drive_byte({st, en, ln, 1'b0, 4'(id)}, 1'b1, 1'b0);
    if (ln) drive_byte({2'b00, 6'(cnt)}, 1'b0, n == 0);
    for (int i = 0; i < n; i++) begin
      drive_byte(8'(base + i), 1'b0, i == n - 1);
      if (probe && i == 3) begin
        @(posedge clk); #1;
        check(out_valid[id] && out_sof[id] && out_data[id*8 +: 8] == base,
              "R6", "cut-through first byte", {out_valid[id], out_sof[id]}, 3);
      end
    end
  endtask

  task automatic drain();
    idle(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_open[p] = 0; m_sofp[p] = 0; und_cnt[p] = 0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == '0 && out_underrun == '0 && !proto_err && orphan_cnt == 0,
          "R10", "reset outputs", {out_valid, out_underrun}, 0);
    rst = 1'b0;
    idle(2);

    // R1 R2 R3: single-segment frames on several ports
    cur_req = "R1";
    send_seg(5, 1, 1, 0, 0, 6, 8'h10, 0);
    send_seg(0, 1, 1, 0, 0, 3, 8'h20, 0);
    send_seg(15, 1, 1, 0, 0, 4, 8'h30, 0);
    drain();
    check(und_cnt[5] == 0 && und_cnt[0] == 0, "R9", "no underrun single segment",
          und_cnt[5] + und_cnt[0], 0);

    // R2 R3: interleaved multi-segment frames
    cur_req = "R2";
    send_seg(2, 1, 0, 0, 0, 4, 8'h40, 0);
    send_seg(9, 1, 0, 0, 0, 2, 8'h50, 0);
    send_seg(2, 0, 0, 0, 0, 3, 8'h60, 0);
    send_seg(9, 0, 1, 0, 0, 3, 8'h70, 0);
    send_seg(2, 0, 1, 0, 0, 2, 8'h80, 0);
    drain();

    // R4: length field trims or passes short segments
    cur_req = "R4";
    send_seg(7, 1, 1, 1, 3, 6, 8'h90, 0);
    send_seg(7, 1, 1, 1, 10, 4, 8'hA0, 0);
    drain();

    // R5: zero count and header-only segments
    cur_req = "R5";
    send_seg(4, 1, 0, 1, 0, 3, 8'hB0, 0);
    send_seg(4, 0, 1, 0, 0, 2, 8'hB8, 0);
    send_seg(6, 1, 1, 0, 0, 0, 8'h00, 0);
    drain();
    check(seen_proto == exp_proto, "R5", "proto_err pulses", seen_proto, exp_proto);
    check(orphan_cnt == 0, "R5", "header-only left no state", orphan_cnt, 0);
    cur_req = "R8";
    send_seg(6, 0, 1, 0, 0, 2, 8'hC0, 0);
    drain();
    check(orphan_cnt == 8'(exp_orphan), "R8", "orphan after header-only", orphan_cnt, exp_orphan);

    // R6: cut-through latency probe
    cur_req = "R6";
    send_seg(3, 1, 1, 0, 0, 7, 8'hC8, 1);
    drain();

    // R7: re-open while a frame is open, with another link interleaved
    cur_req = "R7";
    send_seg(11, 1, 0, 0, 0, 3, 8'hD0, 0);
    send_seg(13, 1, 0, 0, 0, 2, 8'hD8, 0);
    send_seg(11, 1, 1, 0, 0, 2, 8'hE0, 0);
    send_seg(13, 0, 1, 0, 0, 1, 8'hE8, 0);
    drain();

    // R8: stray continuation on a closed link
    cur_req = "R8";
    send_seg(12, 0, 0, 0, 0, 3, 8'hF0, 0);
    send_seg(12, 0, 1, 0, 0, 2, 8'hF4, 0);
    drain();
    check(orphan_cnt == 8'(exp_orphan), "R8", "orphan count", orphan_cnt, exp_orphan);
    check(exp_q[12].size() == 0, "R8", "nothing on port 12", exp_q[12].size(), 0);

    // R9: stall mid-frame
    cur_req = "R9";
    und_cnt[8] = 0;
    send_seg(8, 1, 0, 0, 0, 3, 8'h01, 0);
    idle(8);
    check(out_underrun[8] && !out_valid[8], "R9", "underrun during stall",
          {out_underrun[8], out_valid[8]}, 2);
    send_seg(8, 0, 1, 0, 0, 2, 8'h04, 0);
    drain();
    check(und_cnt[8] >= 6, "R9", "underrun cycles", und_cnt[8], 6);
    check(out_underrun == '0, "R9", "underrun clear after eof", out_underrun, 0);

    // Final: every predicted entry has appeared
    for (int p = 0; p < NP; p++)
      check(exp_q[p].size() == 0, "R1", $sformatf("leftover port %0d", p), exp_q[p].size(), 0);
    check(seen_proto == exp_proto, "R5", "total proto_err", seen_proto, exp_proto);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule